// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block manages, from the device side, a ring of descriptors that sits in host memory and is shared between host and device. The host sets up the ring through a small register bus. It writes the starting address and the number of slots, then produces work by moving the tail index forward. The block sees that work is pending whenever its head index differs from the tail. It then issues a fetch request for the descriptor at the head and waits until the payload engine reports that the descriptor has been serviced.

After service, the block requests a write to the descriptor's done-flag word, which marks the descriptor complete. Only when that write has been accepted does it advance the head index and raise a one-cycle interrupt request. A host that polls the done flag and a host that reads the head register therefore never see the two disagree.

One descriptor is in flight at a time. Descriptors are taken in ring order and the index wraps at the programmed size. Memory transactions are modelled as valid/ready request ports. Service completion is a single-cycle input.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset, base reads 0, size reads RESET_SIZE (16 by default), head, tail and status read 0, and fetchValid, wbValid and irq are low.
- R2: The register word addresses are: 0 base, 1 size, 2 head, 3 tail and 4 status. Status bit 0 is the sticky error flag and bits 16 and up hold the available count. Writes to head have no effect. A status write with bit 0 set clears the error flag.
- R3: An accepted tail write updates tail, and the available count then reads (tail − head) mod size. The ring counts as empty when head equals tail.
- R4: A tail write is ignored and the error flag is set if the written value is size or more, or if the write would make the available count reach size or more.
- R5: While the ring is non-empty and nothing is in flight, fetchValid rises with fetchAddr = base + head × 16. Both hold stable until fetchReady is seen.
- R6: After the fetch is accepted, the block waits for svcDone. It then raises wbValid with wbAddr = base + head × 16 + 12, the done-flag word. Both hold stable until wbReady is seen.
- R7: The head index advances by one, modulo size, in the cycle after the write-back is accepted and never earlier. irq pulses for exactly that one cycle.
- R8: Descriptors are serviced in index order, wrapping from size − 1 to 0. Fetching stops once head equals tail.
- R9: Base and size writes take effect only while the ring is empty and nothing is in flight. A size write must lie in 2..2^IDX_W − 1; an accepted one resets head and tail to 0. Any other base or size write is ignored.
- R10: fetchValid and wbValid are never high together. svcDone has no effect unless a fetched descriptor is awaiting service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| fetchValid | output | 1 | Descriptor fetch request |
| fetchReady | input | 1 | Fetch request accepted |
| fetchAddr | output | ADDR_W | Address of the descriptor to fetch |
| svcDone | input | 1 | Fetched descriptor has been serviced |
| wbValid | output | 1 | Done-flag write-back request |
| wbReady | input | 1 | Write-back accepted |
| wbAddr | output | ADDR_W | Address of the done-flag word |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A corrupted head or tail index appears at once in the register read-back and in the available count. It appears no later than the next fetch as a wrong fetchAddr. A control sequence that publishes the head early shows as the head read-back changing, or irq rising, while wbValid is still waiting for wbReady; the bench samples exactly that window. A faulty admission check on tail writes shows as a tail value that changed after a write that should have been refused, or as the error flag staying clear, in the cycle after the write.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_BASE = 3'd0;
  localparam logic [REG_AW-1:0] REG_SIZE = 3'd1;
  localparam logic [REG_AW-1:0] REG_HEAD = 3'd2;
  localparam logic [REG_AW-1:0] REG_TAIL = 3'd3;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd4;

  localparam int STAT_AVAIL_LSB = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SERVICE,
    ST_WRBACK,
    ST_UPDATE
  } ringState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic busy;
    logic headInc;
  } ctlStrobe_t;

endpackage

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ringNotEmpty,
  input  logic       fetchReady,
  input  logic       svcDone,
  input  logic       wbReady,
  output logic       fetchValid,
  output logic       wbValid,
  output logic       irq,
  output ctlStrobe_t ctl
);

  ringState_e stateQ, stateD;
  logic       irqQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (ringNotEmpty) stateD = ST_FETCH;
      ST_FETCH:   if (fetchReady)   stateD = ST_SERVICE;
      ST_SERVICE: if (svcDone)      stateD = ST_WRBACK;
      ST_WRBACK:  if (wbReady)      stateD = ST_UPDATE;
      ST_UPDATE:                    stateD = ST_IDLE;
      default:                      stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      irqQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      // interrupt is registered so it lands with the head update
      irqQ   <= (stateQ == ST_UPDATE);
    end
  end

  assign fetchValid  = (stateQ == ST_FETCH);
  assign wbValid     = (stateQ == ST_WRBACK);
  assign irq         = irqQ;
  assign ctl.busy    = (stateQ != ST_IDLE);
  assign ctl.headInc = (stateQ == ST_UPDATE);

endmodule

// File: rtl/ring_ptr_dpath.sv
module ring_ptr_dpath
  import ring_ptr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 8,
  parameter int RESET_SIZE = 16,
  parameter int DESC_BYTES = 16,
  parameter int DD_OFFSET  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  ctlStrobe_t        ctl,
  output logic              ringNotEmpty,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [IDX_W-1:0]  headIdx,
  output logic [IDX_W-1:0]  tailIdx,
  output logic [IDX_W-1:0]  sizeVal,
  output logic [IDX_W-1:0]  availCnt
);

  localparam int STRIDE_SH = $clog2(DESC_BYTES);
  localparam logic [DATA_W-1:0] SIZE_MIN = DATA_W'(2);
  localparam logic [DATA_W-1:0] SIZE_LIM = DATA_W'(1) << IDX_W;

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  sizeQ, headQ, tailQ;
  logic              errQ;

  // distance from b forward to a on a ring of sz slots
  function automatic logic [IDX_W-1:0] ringDist(
    input logic [IDX_W-1:0] a,
    input logic [IDX_W-1:0] b,
    input logic [IDX_W-1:0] sz
  );
    logic [IDX_W:0] t;
    if (a >= b) t = {1'b0, a} - {1'b0, b};
    else        t = {1'b0, a} + {1'b0, sz} - {1'b0, b};
    return t[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] advanceCnt;
  logic [IDX_W:0]   projCnt;
  logic             tailInRange, tailOk, cfgOpen, sizeOk;
  logic             wrBase, wrSize, wrTail, wrStat;
  logic [IDX_W-1:0] headNext;

  assign availCnt     = ringDist(tailQ, headQ, sizeQ);
  assign ringNotEmpty = (headQ != tailQ);

  assign wrBase = regWe && (regAddr == REG_BASE);
  assign wrSize = regWe && (regAddr == REG_SIZE);
  assign wrTail = regWe && (regAddr == REG_TAIL);
  assign wrStat = regWe && (regAddr == REG_STAT);

  // tail admission: in range and no overrun of the head
  assign tailInRange = regWdata < DATA_W'(sizeQ);
  assign advanceCnt  = ringDist(regWdata[IDX_W-1:0], tailQ, sizeQ);
  assign projCnt     = {1'b0, availCnt} + {1'b0, advanceCnt};
  assign tailOk      = tailInRange && (projCnt < {1'b0, sizeQ});

  // geometry may only change on a quiet ring
  assign cfgOpen = !ctl.busy && !ringNotEmpty;
  assign sizeOk  = (regWdata >= SIZE_MIN) && (regWdata < SIZE_LIM);

  assign headNext = (headQ == sizeQ - 1'b1) ? '0 : headQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ <= '0;
      sizeQ <= IDX_W'(RESET_SIZE);
      headQ <= '0;
      tailQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (wrBase && cfgOpen) baseQ <= regWdata[ADDR_W-1:0];
      if (wrSize && cfgOpen && sizeOk) begin
        sizeQ <= regWdata[IDX_W-1:0];
        headQ <= '0;
        tailQ <= '0;
      end else begin
        if (ctl.headInc) headQ <= headNext;
        if (wrTail && tailOk) tailQ <= regWdata[IDX_W-1:0];
      end
      if (wrTail && !tailOk)         errQ <= 1'b1;
      else if (wrStat && regWdata[0]) errQ <= 1'b0;
    end
  end

  // descriptor addressing; one descriptor in flight, always at head
  logic [ADDR_W-1:0] descAddr;
  assign descAddr  = baseQ + (ADDR_W'(headQ) << STRIDE_SH);
  assign fetchAddr = descAddr;
  assign wbAddr    = descAddr + ADDR_W'(DD_OFFSET);

  logic [DATA_W-1:0] statWord;
  always_comb begin
    statWord = '0;
    statWord[0] = errQ;
    statWord[STAT_AVAIL_LSB +: IDX_W] = availCnt;
  end

  always_comb begin
    unique case (regAddr)
      REG_BASE: regRdata = DATA_W'(baseQ);
      REG_SIZE: regRdata = DATA_W'(sizeQ);
      REG_HEAD: regRdata = DATA_W'(headQ);
      REG_TAIL: regRdata = DATA_W'(tailQ);
      REG_STAT: regRdata = statWord;
      default:  regRdata = '0;
    endcase
  end

  assign headIdx = headQ;
  assign tailIdx = tailQ;
  assign sizeVal = sizeQ;

endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import ring_ptr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int RESET_SIZE = 16,
  parameter int DESC_BYTES = 16,
  parameter int DD_OFFSET  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              fetchValid,
  input  logic              fetchReady,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              svcDone,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  output logic              irq
);

  ctlStrobe_t       ctl;
  logic             ringNotEmpty;
  logic [IDX_W-1:0] headIdx, tailIdx, sizeVal, availCnt;

  ring_ptr_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ringNotEmpty (ringNotEmpty),
    .fetchReady   (fetchReady),
    .svcDone      (svcDone),
    .wbReady      (wbReady),
    .fetchValid   (fetchValid),
    .wbValid      (wbValid),
    .irq          (irq),
    .ctl          (ctl)
  );

  ring_ptr_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (32),
    .IDX_W      (IDX_W),
    .RESET_SIZE (RESET_SIZE),
    .DESC_BYTES (DESC_BYTES),
    .DD_OFFSET  (DD_OFFSET)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .regWe        (regWe),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .regRdata     (regRdata),
    .ctl          (ctl),
    .ringNotEmpty (ringNotEmpty),
    .fetchAddr    (fetchAddr),
    .wbAddr       (wbAddr),
    .headIdx      (headIdx),
    .tailIdx      (tailIdx),
    .sizeVal      (sizeVal),
    .availCnt     (availCnt)
  );

endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetchValid,
  input logic              fetchReady,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              wbValid,
  input logic              wbReady,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              irq,
  input logic [IDX_W-1:0]  headIdx,
  input logic [IDX_W-1:0]  tailIdx,
  input logic [IDX_W-1:0]  sizeVal,
  input logic [IDX_W-1:0]  availCnt
);

  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid && !fetchReady |=> fetchValid && $stable(fetchAddr));

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid && !wbReady |=> wbValid && $stable(wbAddr));

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetchValid && wbValid));

  // R7
  irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wbValid && wbReady, 2));

  // R7
  head_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$stable(headIdx));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  head_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(headIdx) && !irq) |-> (headIdx == '0 && tailIdx == '0));

  // R3
  avail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    availCnt < sizeVal);

  // R8
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    headIdx < sizeVal && tailIdx < sizeVal);

endmodule

bind ring_ptr_mgr ring_ptr_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetchValid (fetchValid),
  .fetchReady (fetchReady),
  .fetchAddr  (fetchAddr),
  .wbValid    (wbValid),
  .wbReady    (wbReady),
  .wbAddr     (wbAddr),
  .irq        (irq),
  .headIdx    (headIdx),
  .tailIdx    (tailIdx),
  .sizeVal    (sizeVal),
  .availCnt   (availCnt)
);

// File: tb/tb_ring_ptr_mgr.sv
module tb_ring_ptr_mgr;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          regWe = 1'b0;
  logic [2:0]    regAddr = 3'd0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic          fetchValid, wbValid, irq;
  logic          fetchReady = 1'b0, svcDone = 1'b0, wbReady = 1'b0;
  logic [AW-1:0] fetchAddr, wbAddr;

  int total = 0;
  int bad   = 0;
  logic [31:0] curBase = '0;

  always #5 clk = ~clk;

  ring_ptr_mgr dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .fetchValid(fetchValid),
    .fetchReady(fetchReady), .fetchAddr(fetchAddr), .svcDone(svcDone),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // one full descriptor cycle at index idx; nxt is the expected head after it
  task automatic serviceOne(input int idx, input int nxt);
    logic [31:0] expDesc;
    expDesc = curBase + 32'(idx * 16);
    for (int i = 0; i < 50 && !fetchValid; i++) @(negedge clk);
    #1;
    chk("R5 fetchValid", 32'(fetchValid), 1);
    chk("R5 fetchAddr", fetchAddr, expDesc);
    chk("R10 no wb during fetch", 32'(wbValid), 0);
    // stray completion while fetch pending must be ignored
    @(negedge clk); svcDone = 1'b1;
    @(negedge clk); svcDone = 1'b0; #1;
    chk("R5 fetch held", 32'(fetchValid), 1);
    chk("R5 fetchAddr stable", fetchAddr, expDesc);
    @(negedge clk); fetchReady = 1'b1;
    @(negedge clk); fetchReady = 1'b0; #1;
    chk("R6 fetch dropped", 32'(fetchValid), 0);
    chk("R10 stray svcDone ignored", 32'(wbValid), 0);
    @(negedge clk); #1;
    chk("R6 waits for svcDone", 32'(wbValid), 0);
    svcDone = 1'b1;
    @(negedge clk); svcDone = 1'b0; #1;
    chk("R6 wbValid", 32'(wbValid), 1);
    chk("R6 wbAddr", wbAddr, expDesc + 32'd12);
    @(negedge clk); regAddr = 3'd2; #1;
    chk("R6 wb held", 32'(wbValid), 1);
    chk("R7 head not early", regRdata, 32'(idx));
    wbReady = 1'b1;
    @(negedge clk); wbReady = 1'b0; #1;
    chk("R7 head after wb accept", regRdata, 32'(idx));
    chk("R7 irq not yet", 32'(irq), 0);
    @(negedge clk); #1;
    chk("R7 irq pulse", 32'(irq), 1);
    chk("R7 head advanced", regRdata, 32'(nxt));
    @(negedge clk); #1;
    chk("R7 irq one cycle", 32'(irq), 0);
  endtask

  task automatic expectIdle(input string req);
    for (int i = 0; i < 5; i++) @(negedge clk);
    #1;
    chk(req, 32'(fetchValid | wbValid), 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 base", d, 0);
    rd(3'd1, d); chk("R1 size", d, 16);
    rd(3'd2, d); chk("R1 head", d, 0);
    rd(3'd3, d); chk("R1 tail", d, 0);
    rd(3'd4, d); chk("R1 status", d, 0);
    chk("R1 outputs idle", {29'd0, fetchValid, wbValid, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(3'd0, 32'h1000_0000); curBase = 32'h1000_0000;
    rd(3'd0, d); chk("R2 base readback", d, 32'h1000_0000);
    wr(3'd2, 32'd7);
    rd(3'd2, d); chk("R2 head write ignored", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(3'd3, 32'd3);
    rd(3'd3, d); chk("R3 tail accepted", d, 3);
    rd(3'd4, d); chk("R3 avail", d[23:16], 3);
    for (int k = 0; k < 3; k++) serviceOne(k, k + 1);
    rd(3'd4, d); chk("R3 empty avail", d[23:16], 0);
    expectIdle("R8 stops when empty");
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    wr(3'd3, 32'd20);
    rd(3'd3, d); chk("R4 tail beyond size ignored", d, 3);
    rd(3'd4, d); chk("R4 error set", d[0], 1);
    chk("R4 no fetch", 32'(fetchValid), 0);
    wr(3'd4, 32'd1);
    rd(3'd4, d); chk("R2 error cleared", d[0], 0);
    wr(3'd3, 32'd2);
    rd(3'd4, d); chk("R3 avail wraps", d[23:16], 15);
    wr(3'd3, 32'd3);
    rd(3'd3, d); chk("R4 overrun ignored", d, 2);
    rd(3'd4, d); chk("R4 overrun error", d[0], 1);
    wr(3'd1, 32'd8);
    rd(3'd1, d); chk("R9 size locked while busy", d, 16);
    wr(3'd0, 32'h5000_0000);
    rd(3'd0, d); chk("R9 base locked while busy", d, curBase);
    wr(3'd4, 32'd1);
    for (int k = 0; k < 15; k++) serviceOne((3 + k) % 16, (4 + k) % 16);
    rd(3'd2, d); chk("R8 wrapped head", d, 2);
    expectIdle("R8 idle after wrap");
  endtask

  task automatic t_resize();
    logic [31:0] d;
    wr(3'd1, 32'd1);
    rd(3'd1, d); chk("R9 size too small ignored", d, 16);
    wr(3'd1, 32'd5);
    rd(3'd1, d); chk("R9 size accepted", d, 5);
    rd(3'd2, d); chk("R9 head reset", d, 0);
    rd(3'd3, d); chk("R9 tail reset", d, 0);
    wr(3'd0, 32'h2000_0040); curBase = 32'h2000_0040;
    rd(3'd0, d); chk("R9 base accepted when empty", d, curBase);
    @(negedge clk); svcDone = 1'b1;
    @(negedge clk); svcDone = 1'b0;
    expectIdle("R10 svcDone idle ignored");
    wr(3'd3, 32'd4);
    for (int k = 0; k < 4; k++) serviceOne(k, k + 1);
    wr(3'd3, 32'd2);
    rd(3'd4, d); chk("R3 avail small ring", d[23:16], 3);
    serviceOne(4, 0);
    serviceOne(0, 1);
    serviceOne(1, 2);
    wr(3'd3, 32'd5);
    rd(3'd3, d); chk("R4 tail equal size ignored", d, 2);
    rd(3'd4, d); chk("R4 error on size value", d[0], 1);
    expectIdle("R8 done small ring");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_basic();
    t_overflow();
    t_resize();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule